// File: doc/BRIEF.md
# SPI-Mode Memory Card Bring-Up Sequencer

This block walks a removable flash memory card from power-up to a classified, ready state over its SPI-mode command set. It does not shift bits itself. It drives a lower command engine one request at a time. Each request carries a command index, a 32-bit argument and a CRC byte, and it is qualified by a single-cycle start strobe. The engine answers with a done strobe, a timeout flag, the one-byte R1 status and an optional trailing 32-bit word. For the card-specific-data read, the engine also streams four 32-bit words.

After a start pulse, the sequencer asks for a run of idle clocks with chip select released. It then resets the card and probes the interface condition. Whether that probe is answered correctly selects one of two identification branches. The sequencer reads the operating-condition register and polls the application operating-condition command, which is always prefixed by the application-escape command. In the legacy branch it falls back to a second reset followed by the multimedia-card operating-condition command. Once the card family is known, the sequencer switches CRC checking off and captures the 128-bit card-specific register. It then pulses done together with a card-type code, a high-capacity flag and an error flag.

Top module: `sdspi_init_seq`

## Requirements
- R1: After `start`, the first engine request has `cmd_preamble`=1 with `cmd_arg` equal to PREAMBLE_CLKS (at least 74). The next request is index 0 with CRC byte 0x95. Any failure of index 0 ends the run with an error.
- R2: Index 8 follows index 0, with argument 0x000001AA and CRC byte 0x87. The answer is valid only if there is no timeout, R1 bits [7:1] are all zero, trailing bits [11:8] are 0x1 and trailing bits [7:0] are 0xAA. A valid answer selects the version-2 branch; any other answer selects the legacy branch.
- R3: Index 58 follows index 8 in both branches. A timeout or any set R1 bit in [7:1] ends the run with an error.
- R4: Every request with index 41 is immediately preceded by a request with index 55. A failed index 55 counts as a failed index 41.
- R5: The index 41 argument is 0x40000000 in the version-2 branch and 0x00000000 in the legacy branch.
- R6: Index 41 (with its prefix) and index 1 are reissued while R1 bit 0 (idle) is set. After MAX_TRIES attempts that each return idle, the command counts as failed.
- R7: In the version-2 branch, a failed index 41 ends the run with an error. On success, trailing bit 30 = 1 gives card_type 4 with `card_hc`=1, and bit 30 = 0 gives card_type 3 with `card_hc`=0.
- R8: In the legacy branch, a successful index 41 gives card_type 2 with `card_hc`=0, whatever trailing bit 30 holds.
- R9: In the legacy branch, a failed index 41 leads to index 0 and then index 1. An index 1 success gives card_type 1. A timeout, an error bit or retry exhaustion ends the run with an error.
- R10: After classification, index 59 with argument 0 is issued, then index 9. The four words strobed by `cmd_word_vld` during index 9 form `csd`, first word in bits [127:96].
- R11: `init_done` is a one-cycle pulse at the end of each run. On error, `init_err`=1, card_type=0 and `card_hc`=0.
- R12: `start` is ignored while a run is in progress. `cmd_start` is a one-cycle strobe, and no new request is issued before the previous one's `cmd_done`.
- R13: While reset is held, `cmd_start`, `init_done`, `init_err`, `card_hc`, `card_type` and `csd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| cmd_start | output | 1 | One-cycle request strobe to the command engine |
| cmd_preamble | output | 1 | Request is a run of idle clocks with chip select released |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument, or idle clock count for a preamble |
| cmd_crc | output | 8 | CRC byte including stop bit |
| cmd_done | input | 1 | Engine finished the current request |
| cmd_timeout | input | 1 | No response was received |
| cmd_r1 | input | 8 | R1 status byte |
| cmd_resp | input | 32 | Trailing response word, or CSD word when strobed |
| cmd_word_vld | input | 1 | One CSD word is present on cmd_resp |
| init_done | output | 1 | Run finished (pulse) |
| init_err | output | 1 | Last run ended in failure |
| card_type | output | 3 | 0 none, 1 MMC, 2 SD v1.x, 3 SD v2 standard, 4 SD v2 high capacity |
| card_hc | output | 1 | Block-addressed high-capacity card |
| csd | output | 128 | Captured card-specific register |

## Verification
A request appears on `cmd_start` in the cycle after the clock edge that accepts the previous `cmd_done`. The engine model therefore samples it at the falling edge straight after it clears `cmd_done`, and never waits an extra cycle. The classification outputs are registered on the same edge that raises `init_done`, one edge after the final `cmd_done`. The bench waits for `init_done` at falling edges, checks type, flags, CSD and per-command counts at that edge, and confirms the pulse has gone at the next falling edge.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PRE, ST_RST, ST_IFC, ST_OCR, ST_APP,
      ST_AOP, ST_RST2, ST_MOP, ST_CRCOFF, ST_CSD
   } seq_state_t;

   typedef enum logic [2:0] {
      CT_NONE   = 3'd0,
      CT_MMC    = 3'd1,
      CT_SD1    = 3'd2,
      CT_SD2_SC = 3'd3,
      CT_SD2_HC = 3'd4
   } card_kind_t;

   localparam logic [5:0]  IX_RESET   = 6'd0;
   localparam logic [5:0]  IX_MMC_OP  = 6'd1;
   localparam logic [5:0]  IX_IFCOND  = 6'd8;
   localparam logic [5:0]  IX_CSD     = 6'd9;
   localparam logic [5:0]  IX_APPESC  = 6'd55;
   localparam logic [5:0]  IX_RD_OCR  = 6'd58;
   localparam logic [5:0]  IX_CRC_OFF = 6'd59;
   localparam logic [5:0]  IX_SD_OP   = 6'd41;

   localparam logic [7:0]  CRC_RESET  = 8'h95;
   localparam logic [7:0]  CRC_IFCOND = 8'h87;
   localparam logic [7:0]  CRC_NONE   = 8'hFF;

   localparam logic [3:0]  IFC_VOLT   = 4'h1;
   localparam logic [7:0]  IFC_ECHO   = 8'hAA;
   localparam logic [31:0] IFC_ARG    = {20'd0, IFC_VOLT, IFC_ECHO};
   localparam logic [31:0] HCS_ARG    = 32'h4000_0000;

endpackage

// File: rtl/sdi_resp_eval.sv
module sdi_resp_eval
   import sdi_pkg::*;
(
   input  logic        timeout_i,
   input  logic [7:0]  r1_i,
   input  logic [11:0] ifc_field_i,
   input  logic        ccs_field_i,
   output logic        ans_ok_o,
   output logic        ans_idle_o,
   output logic        ifc_ok_o,
   output logic        ccs_o
);

   // a reply counts only if it arrived and carries no error flag
   assign ans_ok_o   = !timeout_i && (r1_i[7:1] == 7'd0);
   assign ans_idle_o = ans_ok_o && r1_i[0];
   assign ifc_ok_o   = ans_ok_o && (ifc_field_i[11:8] == IFC_VOLT)
                                && (ifc_field_i[7:0] == IFC_ECHO);
   assign ccs_o      = ccs_field_i;

endmodule

// File: rtl/sdi_cmd_enc.sv
module sdi_cmd_enc
   import sdi_pkg::*;
#(
   parameter int PREAMBLE_CLKS = 80
) (
   input  seq_state_t  state_i,
   input  logic        v2_i,
   output logic        preamble_o,
   output logic [5:0]  index_o,
   output logic [31:0] arg_o,
   output logic [7:0]  crc_o
);

   always_comb begin
      preamble_o = 1'b0;
      index_o    = IX_RESET;
      arg_o      = 32'd0;
      crc_o      = CRC_NONE;
      case (state_i)
         ST_PRE: begin
            preamble_o = 1'b1;
            arg_o      = 32'(PREAMBLE_CLKS);
         end
         ST_RST, ST_RST2: crc_o = CRC_RESET;
         ST_IFC: begin
            index_o = IX_IFCOND;
            arg_o   = IFC_ARG;
            crc_o   = CRC_IFCOND;
         end
         ST_OCR:    index_o = IX_RD_OCR;
         ST_APP:    index_o = IX_APPESC;
         ST_AOP: begin
            index_o = IX_SD_OP;
            arg_o   = v2_i ? HCS_ARG : 32'd0;
         end
         ST_MOP:    index_o = IX_MMC_OP;
         ST_CRCOFF: index_o = IX_CRC_OFF;
         ST_CSD:    index_o = IX_CSD;
         default: ;
      endcase
   end

endmodule

// File: rtl/sdi_retry.sv
module sdi_retry #(
   parameter int MAX_TRIES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic bump_i,
   output logic last_o
);

   generate
      if (MAX_TRIES == 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(MAX_TRIES);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (bump_i) cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == CW'(MAX_TRIES - 1));
      end
   endgenerate

endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
   import sdi_pkg::*;
#(
   parameter int PREAMBLE_CLKS = 80,
   parameter int MAX_TRIES     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   output logic         cmd_start,
   output logic         cmd_preamble,
   output logic [5:0]   cmd_index,
   output logic [31:0]  cmd_arg,
   output logic [7:0]   cmd_crc,
   input  logic         cmd_done,
   input  logic         cmd_timeout,
   input  logic [7:0]   cmd_r1,
   input  logic [31:0]  cmd_resp,
   input  logic         cmd_word_vld,
   output logic         init_done,
   output logic         init_err,
   output logic [2:0]   card_type,
   output logic         card_hc,
   output logic [127:0] csd
);

   localparam int WORD_W = 32;
   localparam int CSD_W  = 4 * WORD_W;

   generate
      if (PREAMBLE_CLKS < 74) begin : g_bad_preamble
         $error("PREAMBLE_CLKS must be at least 74");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
   endgenerate

   seq_state_t         state_q, nxt;
   card_kind_t         kind_q, kind_n;
   logic               wait_q, v2_q, v2_n, hc_q, hc_n, err_q, done_q;
   logic [CSD_W-1:0]   csd_q;
   logic               ans_ok, ans_idle, ifc_ok, ccs;
   logic               accept, end_ok, end_err;
   logic               retry_clr, retry_bump, retry_last;

   assign accept    = wait_q && cmd_done;
   assign cmd_start = (state_q != ST_IDLE) && !wait_q;

   sdi_resp_eval u_eval (
      .timeout_i   (cmd_timeout),
      .r1_i        (cmd_r1),
      .ifc_field_i (cmd_resp[11:0]),
      .ccs_field_i (cmd_resp[30]),
      .ans_ok_o    (ans_ok),
      .ans_idle_o  (ans_idle),
      .ifc_ok_o    (ifc_ok),
      .ccs_o       (ccs)
   );

   sdi_cmd_enc #(.PREAMBLE_CLKS(PREAMBLE_CLKS)) u_enc (
      .state_i    (state_q),
      .v2_i       (v2_q),
      .preamble_o (cmd_preamble),
      .index_o    (cmd_index),
      .arg_o      (cmd_arg),
      .crc_o      (cmd_crc)
   );

   assign retry_clr  = accept && (state_q == ST_OCR || state_q == ST_RST2);
   assign retry_bump = accept && ans_idle && !retry_last &&
                       (state_q == ST_AOP || state_q == ST_MOP);

   sdi_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (retry_clr),
      .bump_i (retry_bump),
      .last_o (retry_last)
   );

   // branch decisions taken on the accepting edge of each reply
   always_comb begin
      nxt     = state_q;
      end_ok  = 1'b0;
      end_err = 1'b0;
      kind_n  = kind_q;
      hc_n    = hc_q;
      v2_n    = v2_q;
      if (accept) begin
         case (state_q)
            ST_PRE: nxt = ST_RST;
            ST_RST: if (ans_ok) nxt = ST_IFC; else end_err = 1'b1;
            ST_IFC: begin
               nxt  = ST_OCR;
               v2_n = ifc_ok;
            end
            ST_OCR: if (ans_ok) nxt = ST_APP; else end_err = 1'b1;
            ST_APP: begin
               if (ans_ok)     nxt = ST_AOP;
               else if (v2_q)  end_err = 1'b1;
               else            nxt = ST_RST2;
            end
            ST_AOP: begin
               if (ans_ok && !ans_idle) begin
                  nxt = ST_CRCOFF;
                  if (v2_q) begin
                     hc_n   = ccs;
                     kind_n = ccs ? CT_SD2_HC : CT_SD2_SC;
                  end else begin
                     kind_n = CT_SD1;
                  end
               end else if (retry_bump) nxt = ST_APP;
               else if (v2_q)           end_err = 1'b1;
               else                     nxt = ST_RST2;
            end
            ST_RST2: if (ans_ok) nxt = ST_MOP; else end_err = 1'b1;
            ST_MOP: begin
               if (ans_ok && !ans_idle) begin
                  nxt    = ST_CRCOFF;
                  kind_n = CT_MMC;
               end else if (retry_bump) nxt = ST_MOP;
               else                     end_err = 1'b1;
            end
            ST_CRCOFF: if (ans_ok) nxt = ST_CSD; else end_err = 1'b1;
            ST_CSD:    if (ans_ok) end_ok = 1'b1; else end_err = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wait_q  <= 1'b0;
         v2_q    <= 1'b0;
         hc_q    <= 1'b0;
         kind_q  <= CT_NONE;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         csd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (state_q == ST_IDLE) begin
            if (start) begin
               state_q <= ST_PRE;
               wait_q  <= 1'b0;
               v2_q    <= 1'b0;
               hc_q    <= 1'b0;
               kind_q  <= CT_NONE;
               err_q   <= 1'b0;
               csd_q   <= '0;
            end
         end else begin
            if (!wait_q) wait_q <= 1'b1;
            if (wait_q && cmd_word_vld && state_q == ST_CSD)
               csd_q <= {csd_q[CSD_W-WORD_W-1:0], cmd_resp};
            if (accept) begin
               wait_q <= 1'b0;
               v2_q   <= v2_n;
               hc_q   <= hc_n;
               kind_q <= kind_n;
               if (end_ok || end_err) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  if (end_err) begin
                     err_q  <= 1'b1;
                     kind_q <= CT_NONE;
                     hc_q   <= 1'b0;
                  end
               end else begin
                  state_q <= nxt;
               end
            end
         end
      end
   end

   assign init_done = done_q;
   assign init_err  = err_q;
   assign card_type = kind_q;
   assign card_hc   = hc_q;
   assign csd       = csd_q;

endmodule

// File: rtl/sdspi_init_seq_chk.sv
module sdspi_init_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_start,
   input logic        cmd_preamble,
   input logic [5:0]  cmd_index,
   input logic [31:0] cmd_arg,
   input logic [7:0]  cmd_crc,
   input logic        cmd_done,
   input logic        init_done,
   input logic        init_err,
   input logic [2:0]  card_type,
   input logic        card_hc
);

   logic [5:0] last_idx;
   logic       pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_idx <= 6'h3F;
         pend     <= 1'b0;
      end else if (cmd_start) begin
         last_idx <= cmd_preamble ? 6'h3F : cmd_index;
         pend     <= 1'b1;
      end else if (cmd_done) begin
         pend     <= 1'b0;
      end
   end

   // R12
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   // R12
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> !pend);

   // R4
   app_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !cmd_preamble && cmd_index == 6'd41) |-> last_idx == 6'd55);

   // R2
   ifc_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !cmd_preamble && cmd_index == 6'd8)
         |-> (cmd_arg == 32'h0000_01AA && cmd_crc == 8'h87));

   // R1
   reset_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !cmd_preamble && cmd_index == 6'd0) |-> cmd_crc == 8'h95);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> !init_done);

   // R11
   err_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && init_err) |-> (card_type == 3'd0 && !card_hc));

   // R7
   hc_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_hc |-> card_type == 3'd4);

endmodule

bind sdspi_init_seq sdspi_init_seq_chk u_chk (.*);

// File: tb/sdspi_init_seq_bench.sv
`timescale 1ns/1ps
module sdspi_init_seq_bench;

   localparam int PRE_CLKS = 80;
   localparam int TRIES    = 8;

   typedef struct packed {
      logic [1:0] c8mode;   // 0 good echo, 1 illegal, 2 wrong echo
      logic       c58f;
      logic       a41f;
      logic [4:0] a41idle;
      logic       ccs;
      logic       c1none;
      logic [4:0] c1idle;
      logic [2:0] xtype;
      logic       xerr;
      logic [4:0] xa41;
      logic [4:0] xc1;
   } scen_t;

   localparam scen_t SCN [0:11] = '{
      '{2'd0, 1'b0, 1'b0, 5'd2,  1'b1, 1'b0, 5'd0,  3'd4, 1'b0, 5'd3, 5'd0},
      '{2'd0, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  3'd3, 1'b0, 5'd1, 5'd0},
      '{2'd0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  3'd0, 1'b1, 5'd0, 5'd0},
      '{2'd0, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  3'd0, 1'b1, 5'd1, 5'd0},
      '{2'd0, 1'b0, 1'b0, 5'd20, 1'b0, 1'b0, 5'd0,  3'd0, 1'b1, 5'd8, 5'd0},
      '{2'd1, 1'b0, 1'b0, 5'd1,  1'b1, 1'b0, 5'd0,  3'd2, 1'b0, 5'd2, 5'd0},
      '{2'd2, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  3'd2, 1'b0, 5'd1, 5'd0},
      '{2'd1, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 5'd1,  3'd1, 1'b0, 5'd1, 5'd2},
      '{2'd1, 1'b0, 1'b1, 5'd0,  1'b0, 1'b1, 5'd0,  3'd0, 1'b1, 5'd1, 5'd1},
      '{2'd1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  3'd0, 1'b1, 5'd0, 5'd0},
      '{2'd1, 1'b0, 1'b0, 5'd20, 1'b0, 1'b0, 5'd0,  3'd1, 1'b0, 5'd8, 5'd1},
      '{2'd1, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 5'd20, 3'd0, 1'b1, 5'd1, 5'd8}
   };

   localparam logic [31:0] W0 = 32'hA1B2_C3D4, W1 = 32'h0F1E_2D3C,
                           W2 = 32'h5566_7788, W3 = 32'h99AA_BBCC;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         cmd_start, cmd_preamble;
   logic [5:0]   cmd_index;
   logic [31:0]  cmd_arg;
   logic [7:0]   cmd_crc;
   logic         cmd_done = 1'b0, cmd_timeout = 1'b0, cmd_word_vld = 1'b0;
   logic [7:0]   cmd_r1 = 8'h00;
   logic [31:0]  cmd_resp = 32'd0;
   logic         init_done, init_err, card_hc;
   logic [2:0]   card_type;
   logic [127:0] csd;

   always #4 clk = ~clk;

   sdspi_init_seq #(.PREAMBLE_CLKS(PRE_CLKS), .MAX_TRIES(TRIES)) u_sdspi_init_seq (
      .clk, .rst_n, .start, .cmd_start, .cmd_preamble, .cmd_index, .cmd_arg,
      .cmd_crc, .cmd_done, .cmd_timeout, .cmd_r1, .cmd_resp, .cmd_word_vld,
      .init_done, .init_err, .card_type, .card_hc, .csd
   );

   int checks = 0, errors = 0;
   bit finished = 0;
   scen_t cur;
   int n_pre, n_req, n_a41, n_c1;
   logic [5:0] prev_idx;

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // command engine model: answers each request according to cur
   task automatic serve();
      logic [5:0]  idx = cmd_index;
      logic [31:0] arg = cmd_arg;
      logic [7:0]  crc = cmd_crc;
      logic        pre = cmd_preamble;
      logic        to  = 1'b0;
      logic [7:0]  r1  = 8'h01;
      logic [31:0] rs  = 32'd0;
      if (pre) begin
         chk(n_req == 0, "R1 preamble first", n_req, 0);
         chk(arg == PRE_CLKS && arg >= 74, "R1 preamble count", arg, PRE_CLKS);
         n_pre++;
         r1 = 8'h00;
      end else begin
         case (idx)
            6'd0: begin
               chk(crc == 8'h95, "R1 reset crc", crc, 8'h95);
               if (n_req == 1) chk(1'b1, "R1 reset second", 0, 0);
            end
            6'd8: begin
               chk(arg == 32'h1AA && crc == 8'h87, "R2 ifcond frame", {arg, crc}, {32'h1AA, 8'h87});
               chk(prev_idx == 6'd0, "R2 ifcond order", prev_idx, 0);
               if (cur.c8mode == 2'd0)      rs = 32'h0000_01AA;
               else if (cur.c8mode == 2'd1) r1 = 8'h05;
               else                         rs = 32'h0000_01A5;
            end
            6'd58: begin
               chk(prev_idx == 6'd8, "R3 ocr order", prev_idx, 8);
               if (cur.c58f) to = 1'b1; else rs = 32'h00FF_8000;
            end
            6'd55: r1 = 8'h01;
            6'd41: begin
               chk(prev_idx == 6'd55, "R4 prefix", prev_idx, 55);
               chk(arg == ((cur.c8mode == 2'd0) ? 32'h4000_0000 : 32'd0), "R5 hcs arg",
                   arg, (cur.c8mode == 2'd0) ? 32'h4000_0000 : 32'd0);
               n_a41++;
               if (cur.a41f)                   r1 = 8'h05;
               else if (n_a41 <= cur.a41idle)  r1 = 8'h01;
               else begin
                  r1 = 8'h00;
                  rs = {1'b0, cur.ccs, 30'd0};
               end
            end
            6'd1: begin
               chk(prev_idx == 6'd0 || prev_idx == 6'd1, "R9 mmc order", prev_idx, 0);
               n_c1++;
               if (cur.c1none) to = 1'b1;
               else r1 = (n_c1 <= cur.c1idle) ? 8'h01 : 8'h00;
            end
            6'd59: begin
               chk(arg == 32'd0, "R10 crc off arg", arg, 0);
               r1 = 8'h00;
            end
            6'd9: begin
               chk(prev_idx == 6'd59, "R10 csd order", prev_idx, 59);
               r1 = 8'h00;
            end
            default: chk(1'b0, "R3 unexpected index", idx, 0);
         endcase
      end
      n_req++;
      prev_idx = pre ? 6'h3F : idx;
      repeat (2) @(negedge clk);
      if (!pre && idx == 6'd9) begin
         for (int w = 0; w < 4; w++) begin
            cmd_resp     = (w == 0) ? W0 : (w == 1) ? W1 : (w == 2) ? W2 : W3;
            cmd_word_vld = 1'b1;
            @(negedge clk);
            cmd_word_vld = 1'b0;
         end
      end
      cmd_timeout = to;
      cmd_r1      = to ? 8'hFF : r1;
      cmd_resp    = rs;
      cmd_done    = 1'b1;
      @(negedge clk);
      cmd_done    = 1'b0;
      cmd_timeout = 1'b0;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         while (cmd_start) serve();
      end
   end

   task automatic clear_counts();
      n_pre = 0; n_req = 0; n_a41 = 0; n_c1 = 0; prev_idx = 6'h3F;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      int k = 0;
      while (!init_done && k < 3000) begin
         @(negedge clk);
         k++;
      end
      seen = init_done;
      if (!seen) chk(1'b0, "R11 done never seen", k, 0);
   endtask

   task automatic run_row(input int row);
      bit seen;
      cur = SCN[row];
      clear_counts();
      pulse_start();
      wait_done(seen);
      if (seen) begin
         chk(init_err == cur.xerr, $sformatf("R11 err row %0d", row), init_err, cur.xerr);
         chk(card_type == cur.xtype, $sformatf("R7 R8 R9 type row %0d", row), card_type, cur.xtype);
         chk(card_hc == (cur.xtype == 3'd4), $sformatf("R7 hc row %0d", row), card_hc, cur.xtype == 3'd4);
         chk(n_a41 == cur.xa41, $sformatf("R6 op polls row %0d", row), n_a41, cur.xa41);
         chk(n_c1 == cur.xc1, $sformatf("R6 mmc polls row %0d", row), n_c1, cur.xc1);
         if (!cur.xerr)
            chk(csd == {W0, W1, W2, W3}, $sformatf("R10 csd row %0d", row), csd, {W0, W1, W2, W3});
         @(negedge clk);
         chk(!init_done, "R11 done pulse width", init_done, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit seen;
      clear_counts();
      cur = SCN[1];
      repeat (3) @(negedge clk);
      // R13 reset values
      chk(!cmd_start && !init_done && !init_err && !card_hc, "R13 reset flags",
          {cmd_start, init_done, init_err, card_hc}, 0);
      chk(card_type == 3'd0 && csd == 128'd0, "R13 reset type csd", {card_type, csd}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int r = 0; r < 12; r++) run_row(r);

      // R12 start while busy is ignored
      cur = SCN[1];
      clear_counts();
      pulse_start();
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      chk(card_type == 3'd3, "R12 run unaffected", card_type, 3);
      repeat (20) @(negedge clk);
      chk(n_pre == 1 && !cmd_start, "R12 single preamble", n_pre, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule